// File: doc/BRIEF.md
# Flash Completion Polling Controller

After a host has written a program or erase command into a parallel flash, this block finds out when the operation ends and how it ended. It latches the target address from a start request. It then reads the status byte at that address again and again through a simple read port that has a request and ready handshake. It compares the busy bit (bit 6) of each read with the read before it. While an operation runs, that bit alternates between reads. Once two reads agree, the operation is over and the result is a pass.

If the failure bit (bit 5) comes back as 1 while the busy bit is still alternating, the controller does not trust that first sight. It takes two further reads. If their busy bits agree, the device had just finished and the result is a pass. If they still differ, the device reports a real failure. A host-programmed limit on the number of polling reads stops a device that never settles, and reaching the limit counts as a failure with a timeout marker. Every failure sets a sticky flag for the sector that holds the target address. The sector index is the top address bits. Software outside this block can then stop using that sector while the other sectors stay in service.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While reset is held and just after it is released, rd_req_o, done_o, pass_o, fail_o and timeout_o are 0 and every bit of bad_sector_o is 0.
- R2: A start_i pulse while the controller is idle latches start_addr_i, and every read of that operation presents that address on rd_addr_o. A start_i that arrives while an operation is running is ignored and does not change the address or begin a second operation.
- R3: A read completes only in a cycle where rd_req_o and rd_ready_i are both 1. Until then rd_req_o stays 1 and rd_addr_o stays unchanged.
- R4: If bit 6 of a read equals bit 6 of the read just before it, the operation ends with a pass.
- R5: If a polling read has bit 6 different from the read before it and bit 5 set to 1, exactly two more reads follow. The operation passes if bit 6 of those two reads is equal and fails otherwise.
- R6: If a polling read brings the operation's read count to max_polls_i or more with no decision, the operation ends with fail_o and timeout_o. For example, with a limit of 6 and a device that never settles, exactly 6 reads are made.
- R7: Each operation produces exactly one done_o pulse, one cycle long, in the cycle after the last read completes. Exactly one of pass_o or fail_o is high in that same cycle, and neither is high at any other time.
- R8: On a fail, bad_sector_o bit [start_addr_i[ADDR_W-1 -: SECT_W]] becomes 1 in the same cycle as fail_o. It stays 1 until reset. No flag changes except with fail_o.
- R9: timeout_o is high only together with fail_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin polling an operation (accepted when idle) |
| start_addr_i | input | ADDR_W | Address being programmed or inside the sector being erased |
| max_polls_i | input | CNT_W | Maximum number of polling reads before timeout |
| rd_req_o | output | 1 | Read request to the flash read port |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | 8 | Status byte returned by the flash |
| rd_ready_i | input | 1 | Read data valid and request accepted this cycle |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| pass_o | output | 1 | Operation succeeded (with done_o) |
| fail_o | output | 1 | Operation failed (with done_o) |
| timeout_o | output | 1 | Failure caused by the poll limit (with fail_o) |
| bad_sector_o | output | 2**SECT_W | Sticky per-sector failure flags |

## Verification
The bench builds the block with a 12-bit address, a 2-bit sector index and an 8-bit poll counter. This gives four sectors, so flags on several sectors can be set and kept apart, and a start request during a busy operation can aim at a different sector than the running one. The narrow counter keeps timeout runs short. A device model driven by a table produces immediate settling, late settling, a failure bit that turns out to be transient, a persistent failure and a device that never settles. The model runs with both a ready line that is always high and one that stalls every other cycle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIRST,
    ST_POLL,
    ST_CHK1,
    ST_CHK2
  } poll_state_t;

  localparam int BUSY_BIT = 6;
  localparam int ERR_BIT  = 5;

  // busy bit identical across two consecutive reads: device has settled
  function automatic logic busy_settled(input logic [7:0] older, input logic [7:0] newer);
    return older[BUSY_BIT] == newer[BUSY_BIT];
  endfunction

  function automatic logic err_reported(input logic [7:0] status);
    return status[ERR_BIT];
  endfunction

  function automatic logic reads_reach_limit(input logic [31:0] reads_after, input logic [31:0] limit);
    return reads_after >= limit;
  endfunction

endpackage

// File: rtl/fpc_poll_counter.sv
module fpc_poll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             at_limit_o
);
  import flash_poll_pkg::*;

  logic [CNT_W-1:0] count_q;
  logic [31:0]      next_reads;

  assign next_reads = 32'(count_q) + 32'd1;
  assign at_limit_o = reads_reach_limit(next_reads, 32'(limit_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (clear_i) begin
      count_q <= '0;
    end else if (inc_i && (count_q != {CNT_W{1'b1}})) begin
      count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/fpc_bad_sector_map.sv
module fpc_bad_sector_map #(
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mark_i,
  input  logic [SECT_W-1:0] sector_i,
  output logic [NSECT-1:0]  map_o
);

  for (genvar s = 0; s < NSECT; s++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_o[s] <= 1'b0;
      end else if (mark_i && (sector_i == SECT_W'(s))) begin
        map_o[s] <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3,
  parameter int CNT_W  = 16,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  input  logic              rd_ready_i,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic              timeout_o,
  output logic [NSECT-1:0]  bad_sector_o
);
  import flash_poll_pkg::*;

  poll_state_t       state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        prev_q, prev_d;

  // named internal events
  logic rd_beat;
  logic start_take;
  logic settled;
  logic err_now;
  logic at_limit;
  logic dec_pass, dec_fail, dec_to, dec_any;
  logic cnt_inc;

  assign rd_req_o   = (state_q != ST_IDLE);
  assign rd_addr_o  = addr_q;
  assign rd_beat    = rd_req_o && rd_ready_i;
  assign start_take = (state_q == ST_IDLE) && start_i;
  assign settled    = busy_settled(prev_q, rd_data_i);
  assign err_now    = err_reported(rd_data_i);
  assign cnt_inc    = rd_beat && ((state_q == ST_FIRST) || (state_q == ST_POLL));
  assign dec_any    = dec_pass || dec_fail;

  fpc_poll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_take),
    .inc_i     (cnt_inc),
    .limit_i   (max_polls_i),
    .at_limit_o(at_limit)
  );

  fpc_bad_sector_map #(.SECT_W(SECT_W)) u_map (
    .clk     (clk),
    .rst_n   (rst_n),
    .mark_i  (dec_fail),
    .sector_i(addr_q[ADDR_W-1 -: SECT_W]),
    .map_o   (bad_sector_o)
  );

  always_comb begin
    state_d  = state_q;
    prev_d   = prev_q;
    dec_pass = 1'b0;
    dec_fail = 1'b0;
    dec_to   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) state_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (rd_beat) begin
          prev_d  = rd_data_i;
          state_d = ST_POLL;
        end
      end
      ST_POLL: begin
        if (rd_beat) begin
          if (settled) begin
            dec_pass = 1'b1;
          end else if (err_now) begin
            state_d = ST_CHK1;
          end else if (at_limit) begin
            dec_fail = 1'b1;
            dec_to   = 1'b1;
          end else begin
            prev_d = rd_data_i;
          end
        end
      end
      ST_CHK1: begin
        if (rd_beat) begin
          prev_d  = rd_data_i;
          state_d = ST_CHK2;
        end
      end
      ST_CHK2: begin
        if (rd_beat) begin
          if (settled) dec_pass = 1'b1;
          else         dec_fail = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (dec_pass || dec_fail) state_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      prev_q    <= '0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      fail_o    <= 1'b0;
      timeout_o <= 1'b0;
    end else begin
      state_q   <= state_d;
      prev_q    <= prev_d;
      if (start_take) addr_q <= start_addr_i;
      done_o    <= dec_any;
      pass_o    <= dec_pass;
      fail_o    <= dec_fail;
      timeout_o <= dec_to;
    end
  end

endmodule

// File: rtl/fpc_checker.sv
module fpc_checker #(
  parameter int ADDR_W = 16,
  parameter int NSECT  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req_o,
  input logic              rd_ready_i,
  input logic [ADDR_W-1:0] rd_addr_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              fail_o,
  input logic              timeout_o,
  input logic [NSECT-1:0]  bad_sector_o,
  input logic              dec_any
);

  a_r7_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pass_o ^ fail_o));

  a_r7_result_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_o || fail_o) |-> done_o);

  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r7_follows_decision: assert property (@(posedge clk) disable iff (!rst_n)
    dec_any |=> done_o);

  a_r9_timeout_with_fail: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> fail_o);

  a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> rd_req_o);

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_o && !rd_ready_i) |=> $stable(rd_addr_o));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((bad_sector_o & $past(bad_sector_o)) == $past(bad_sector_o)));

  a_r8_change_only_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_sector_o != $past(bad_sector_o)) |-> fail_o);

endmodule

bind flash_poll_ctrl fpc_checker #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rd_req_o    (rd_req_o),
  .rd_ready_i  (rd_ready_i),
  .rd_addr_o   (rd_addr_o),
  .done_o      (done_o),
  .pass_o      (pass_o),
  .fail_o      (fail_o),
  .timeout_o   (timeout_o),
  .bad_sector_o(bad_sector_o),
  .dec_any     (dec_any)
);

// File: tb/sim_flash_poll_ctrl.sv
module sim_flash_poll_ctrl;
  localparam int ADDR_W = 12;
  localparam int SECT_W = 2;
  localparam int CNT_W  = 8;
  localparam int NSECT  = 1 << SECT_W;
  localparam int NEVER  = 255;

  typedef struct packed {
    logic [7:0] settle_at;  // read index at which busy bit freezes
    logic [7:0] err_from;   // read index from which bit 5 is 1 while busy
    logic [7:0] limit;
    logic [1:0] sect;
    logic       stall;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{8'd3,   8'd255, 8'd20, 2'd0, 1'b0},  // late settle: pass
    '{8'd0,   8'd255, 8'd20, 2'd1, 1'b0},  // already settled: pass, 2 reads
    '{8'd3,   8'd2,   8'd20, 2'd2, 1'b0},  // transient error bit: pass
    '{8'd255, 8'd5,   8'd20, 2'd3, 1'b0},  // persistent error: fail
    '{8'd255, 8'd255, 8'd6,  2'd2, 1'b0},  // never settles: timeout
    '{8'd5,   8'd255, 8'd20, 2'd0, 1'b1},  // stalled ready: pass
    '{8'd255, 8'd4,   8'd30, 2'd1, 1'b1}   // stalled ready: fail
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [CNT_W-1:0]  max_polls_i = '0;
  logic              rd_req_o;
  logic [ADDR_W-1:0] rd_addr_o;
  logic [7:0]        rd_data_i = '0;
  logic              rd_ready_i = 1'b0;
  logic              done_o, pass_o, fail_o, timeout_o;
  logic [NSECT-1:0]  bad_sector_o;

  always #4 clk = ~clk;

  flash_poll_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_addr_i(start_addr_i),
    .max_polls_i(max_polls_i), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i), .rd_ready_i(rd_ready_i), .done_o(done_o),
    .pass_o(pass_o), .fail_o(fail_o), .timeout_o(timeout_o),
    .bad_sector_o(bad_sector_o)
  );

  int n_checks = 0, n_fail = 0;
  // model and monitor state
  int m_settle = 0, m_err = NEVER, k = 0, beats = 0, addr_bad = 0;
  int n_done = 0, n_pass = 0, n_failp = 0, n_to = 0, cyc = 0;
  logic m_stall = 1'b0, pend = 1'b0, req_q = 1'b0;
  logic [ADDR_W-1:0] exp_addr = '0;
  logic [NSECT-1:0]  exp_bad = '0;

  function automatic logic [7:0] dq(input int idx, input int st, input int er);
    logic [7:0] r = 8'h0C;
    if (idx < st) r[6] = idx[0];
    else          r[6] = st[0];
    r[5] = (idx >= er) && (idx < st);
    return r;
  endfunction

  // outcome: 0 pass, 1 fail, 2 timeout
  task automatic predict(input int st, input int er, input int lim,
                         output int outcome, output int reads);
    logic [7:0] prev, cur, c1, c2;
    prev = dq(0, st, er);
    outcome = 2; reads = 0;
    for (int i = 1; i < 250; i++) begin
      cur = dq(i, st, er);
      if (cur[6] == prev[6]) begin outcome = 0; reads = i + 1; return; end
      if (cur[5]) begin
        c1 = dq(i + 1, st, er); c2 = dq(i + 2, st, er);
        outcome = (c1[6] == c2[6]) ? 0 : 1; reads = i + 3; return;
      end
      if (i + 1 >= lim) begin outcome = 2; reads = i + 1; return; end
      prev = cur;
    end
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pend) k++;
    if (rd_req_o && !req_q) k = 0;
    req_q = rd_req_o;
    rd_ready_i = m_stall ? cyc[0] : 1'b1;
    rd_data_i  = dq(k, m_settle, m_err);
    pend = rd_req_o && rd_ready_i;
    if (pend) beats++;
    if (rd_req_o && (rd_addr_o != exp_addr)) addr_bad++;
    if (done_o) n_done++;
    if (pass_o) n_pass++;
    if (fail_o) n_failp++;
    if (timeout_o) n_to++;
  end

  task automatic wait_done(input int d0);
    int w = 0;
    while (n_done == d0 && w < 2000) begin @(negedge clk); #1; w++; end
    if (w >= 2000) chk(1'b0, "watchdog", w, 0);
    repeat (3) begin @(negedge clk); #1; end
  endtask

  task automatic run_op(input vec_t v, input logic busy_start);
    int outcome, reads, b0, d0, p0, f0, t0, a0;
    predict(int'(v.settle_at), int'(v.err_from), int'(v.limit), outcome, reads);
    m_settle = v.settle_at; m_err = v.err_from; m_stall = v.stall;
    @(negedge clk); #1;
    b0 = beats; d0 = n_done; p0 = n_pass; f0 = n_failp; t0 = n_to; a0 = addr_bad;
    exp_addr = {v.sect, 10'(37 * (cyc % 27) + 5)};
    start_addr_i = exp_addr; max_polls_i = v.limit; start_i = 1'b1;
    @(negedge clk); #1;
    start_i = 1'b0;
    if (busy_start) begin
      @(negedge clk); #1;
      start_addr_i = {v.sect + 2'd2, 10'h155}; start_i = 1'b1;
      @(negedge clk); #1;
      start_i = 1'b0;
    end
    wait_done(d0);
    if (outcome != 0) exp_bad[v.sect] = 1'b1;
    chk(n_done - d0 == 1, "R7 one done pulse", n_done - d0, 1);
    chk(n_pass - p0 == (outcome == 0 ? 1 : 0), "R4/R5 pass pulse", n_pass - p0, outcome == 0);
    chk(n_failp - f0 == (outcome != 0 ? 1 : 0), "R5/R6 fail pulse", n_failp - f0, outcome != 0);
    chk(n_to - t0 == (outcome == 2 ? 1 : 0), "R6 R9 timeout pulse", n_to - t0, outcome == 2);
    chk(beats - b0 == reads, "R3 R4 R5 R6 read count", beats - b0, reads);
    chk(addr_bad == a0, "R2 poll address", addr_bad - a0, 0);
    chk(bad_sector_o == exp_bad, "R8 bad sector map", int'(bad_sector_o), int'(exp_bad));
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog global", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(rd_req_o == 0, "R1 rd_req in reset", rd_req_o, 0);
    chk({done_o, pass_o, fail_o, timeout_o} == 0, "R1 pulses in reset",
        {done_o, pass_o, fail_o, timeout_o}, 0);
    chk(bad_sector_o == 0, "R1 map in reset", bad_sector_o, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(rd_req_o == 0 && done_o == 0, "R1 idle after reset", rd_req_o, 0);

    for (int i = 0; i < NV; i++) run_op(VECS[i], 1'b0);

    // start while busy is ignored; fail lands on the running op's sector only
    run_op('{8'd255, 8'd4, 8'd40, 2'd0, 1'b0}, 1'b1);
    chk(bad_sector_o[2] == exp_bad[2], "R2 busy start ignored sector", bad_sector_o[2], exp_bad[2]);
    // pass after failures leaves flags as they were
    run_op('{8'd1, 8'd255, 8'd20, 2'd3, 1'b1}, 1'b0);

    // reset clears sticky flags
    rst_n = 1'b0;
    @(negedge clk); #1;
    chk(bad_sector_o == 0, "R1 R8 flags cleared by reset", bad_sector_o, 0);
    rst_n = 1'b1;
    exp_bad = '0;
    @(negedge clk); #1;
    // limit below two: timeout after the second read
    run_op('{8'd255, 8'd255, 8'd1, 2'd1, 1'b0}, 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule